// File: doc/BRIEF.md
# Partitioned Packet Queue Memory

This block holds one shared word store that is split into three first-in first-out queues. Two carry outbound traffic: one for asynchronous packets and one for isochronous packets. The third carries inbound traffic. The host pushes words into the two outbound queues, and the packet transmitter pops them. The packet receiver pushes words into the inbound queue, and the host pops them. Each queue keeps its own pointers and its own full, empty, overflow and underflow indications. The full bits are meant to feed an interrupt controller.

Software places the queues by giving each one a base word address and a length in words. It may only do this while the queues are switched off, and every accepted layout change clears all the queues.

The receive queue fills in two steps. Words from the receiver land behind a provisional pointer. They become visible to the host only when the last word of a good packet arrives. If the receiver reports a damaged packet, the provisional pointer falls back to the last committed point, so the bad packet disappears and its space is given back.

Top module: `tri_part_fifo`

## Requirements
- R1: After reset every queue is empty and not full, and the sticky bits are clear. The default layout gives the asynchronous queue words 0..255, the isochronous queue words 256..511 and the receive queue words 512..1023, so the isochronous queue reports full after exactly 256 writes.
- R2: Each queue returns words in the order they were written. Read data appears on the queue's data output in the cycle after an accepted read strobe and holds until the next accepted read.
- R3: A queue reports full when its stored words equal its length. A write to a full queue is dropped and sets that queue's sticky overflow bit only.
- R4: A read from an empty queue is dropped: the data output does not change and the queue's sticky underflow bit is set.
- R5: Each queue wraps inside its own base and length, and traffic on one queue never alters the contents or flags of another.
- R6: Words written to the receive queue stay invisible to the host, and the queue stays empty for reading, until a write with rcvLast high commits them together with that word.
- R7: rcvAbort discards every word written since the last commit and frees their space. A receive write in the same cycle as rcvAbort is dropped.
- R8: The receive queue counts uncommitted words toward its full indication.
- R9: A layout write is taken only while partEn is low. cfgSel selects the queue (0 asynchronous, 1 isochronous, 2 receive). An accepted layout write empties all three queues and clears all sticky bits. While partEn is high, layout writes are ignored.
- R10: While partEn is low, read and write strobes on every queue are ignored and set no sticky bit.
- R11: A read and a write to the same queue in one cycle are both judged against the state at the start of that cycle, and both take effect.
- R12: Every per-queue flag vector uses bit 0 for the asynchronous queue, bit 1 for the isochronous queue and bit 2 for the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| partEn | input | 1 | Queues enabled; layout locked while high |
| cfgWe | input | 1 | Layout write strobe |
| cfgSel | input | 2 | Queue selected by the layout write |
| cfgBase | input | 10 | Base word address for the selected queue |
| cfgSize | input | 11 | Length in words for the selected queue |
| asyWe | input | 1 | Host write into the asynchronous queue |
| asyWdata | input | 32 | Host data for the asynchronous queue |
| isoWe | input | 1 | Host write into the isochronous queue |
| isoWdata | input | 32 | Host data for the isochronous queue |
| txAsyRe | input | 1 | Transmitter read from the asynchronous queue |
| txAsyData | output | 32 | Asynchronous read data |
| txIsoRe | input | 1 | Transmitter read from the isochronous queue |
| txIsoData | output | 32 | Isochronous read data |
| rcvWe | input | 1 | Receiver write into the receive queue |
| rcvWdata | input | 32 | Receiver data |
| rcvLast | input | 1 | Marks the last word of a good packet; commits it |
| rcvAbort | input | 1 | Discards the uncommitted packet |
| hostRe | input | 1 | Host read from the receive queue |
| hostRdata | output | 32 | Receive read data |
| full | output | 3 | Full flag per queue |
| empty | output | 3 | Empty flag per queue |
| ovfl | output | 3 | Sticky overflow per queue |
| udfl | output | 3 | Sticky underflow per queue |

## Verification
The risky overlap on the receive queue is a host read landing in the same cycle as a receiver commit or a receiver abort. The committed count then has to absorb a decrement and an increment at once, and the rewind must not disturb the read pointer. The bench provokes this by issuing hostRe together with a committing write, and later by following an abort directly with reads. It judges the result by the exact words the host gets back and by the empty and full bits on the next cycle. The same overlap is also driven on the asynchronous queue, with a write that wraps past the end of the region while a read is accepted.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int AW = 10;            // word address width of the shared store
  localparam int DW = 32;            // word width
  localparam int NP = 3;             // number of queues
  localparam int SW = AW + 1;        // length and count width
  localparam int DEPTH = 1 << AW;
  localparam int P_ASY = 0;
  localparam int P_ISO = 1;
  localparam int P_RCV = 2;

  typedef struct packed {
    logic [NP-1:0]         wrEn;
    logic [NP-1:0][AW-1:0] wrAddr;
    logic [NP-1:0]         rdEn;
    logic [NP-1:0][AW-1:0] rdAddr;
  } memStb_t;
endpackage

// File: rtl/tpf_ptr.sv
module tpf_ptr
  import tpf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          commit,
  input  logic          abort,
  input  logic [SW-1:0] size,
  output logic [AW-1:0] wrOff,
  output logic [AW-1:0] rdOff,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf,
  output logic          pushOk,
  output logic          popOk
);
  logic [SW-1:0] cnt, pend;
  logic [AW-1:0] cwOff, wrNext;

  function automatic logic [AW-1:0] stepOff(input logic [AW-1:0] off, input logic [SW-1:0] lim);
    return ({1'b0, off} + SW'(1) == lim) ? '0 : off + AW'(1);
  endfunction

  assign full   = (cnt + pend) >= size;
  assign empty  = (cnt == '0);
  assign pushOk = push & ~full & ~abort;
  assign popOk  = pop & ~empty;
  assign wrNext = pushOk ? stepOff(wrOff, size) : wrOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrOff <= '0; rdOff <= '0; cwOff <= '0;
      cnt <= '0; pend <= '0; ovf <= 1'b0; udf <= 1'b0;
    end else if (clr) begin
      wrOff <= '0; rdOff <= '0; cwOff <= '0;
      cnt <= '0; pend <= '0; ovf <= 1'b0; udf <= 1'b0;
    end else begin
      if (popOk) rdOff <= stepOff(rdOff, size);
      if (abort) begin
        wrOff <= cwOff;
        pend  <= '0;
        cnt   <= cnt - SW'(popOk);
      end else if (commit) begin
        wrOff <= wrNext;
        cwOff <= wrNext;
        pend  <= '0;
        cnt   <= cnt - SW'(popOk) + pend + SW'(pushOk);
      end else begin
        wrOff <= wrNext;
        pend  <= pend + SW'(pushOk);
        cnt   <= cnt - SW'(popOk);
      end
      ovf <= ovf | (push & full & ~abort);
      udf <= udf | (pop & empty);
    end
  end

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rstN)
    push && full && !abort && !clr |=> ovf);
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovf && !clr |=> ovf);
  a_r4_empty_rd_stable: assert property (@(posedge clk) disable iff (!rstN)
    empty && !clr |=> $stable(rdOff));
  a_r7_abort_drops: assert property (@(posedge clk) disable iff (!rstN)
    abort && !clr |=> pend == '0);
  a_r8_bound: assert property (@(posedge clk) disable iff (!rstN)
    (cnt + pend) <= size);
endmodule

// File: rtl/tpf_ctrl.sv
module tpf_ctrl
  import tpf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          partEn,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [AW-1:0] cfgBase,
  input  logic [SW-1:0] cfgSize,
  input  logic [NP-1:0] pushReq,
  input  logic [NP-1:0] popReq,
  input  logic          rcvLast,
  input  logic          rcvAbort,
  output memStb_t       stb,
  output logic [NP-1:0] full,
  output logic [NP-1:0] empty,
  output logic [NP-1:0] ovf,
  output logic [NP-1:0] udf
);
  logic [NP-1:0][AW-1:0] baseR;
  logic [NP-1:0][SW-1:0] sizeR;
  logic cfgOk;

  function automatic logic [AW-1:0] defBase(input int i);
    return (i == P_ASY) ? AW'(0) : (i == P_ISO) ? AW'(DEPTH / 4) : AW'(DEPTH / 2);
  endfunction
  function automatic logic [SW-1:0] defSize(input int i);
    return (i == P_RCV) ? SW'(DEPTH / 2) : SW'(DEPTH / 4);
  endfunction

  assign cfgOk = cfgWe & ~partEn & (32'(cfgSel) < NP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NP; i++) begin
        baseR[i] <= defBase(i);
        sizeR[i] <= defSize(i);
      end
    end else if (cfgOk) begin
      baseR[cfgSel] <= cfgBase;
      sizeR[cfgSel] <= cfgSize;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_part
    logic commitG, abortG, pushOkG, popOkG;
    logic [AW-1:0] wrOffG, rdOffG;
    if (g == P_RCV) begin : g_prov
      assign commitG = partEn & pushReq[g] & rcvLast;
      assign abortG  = partEn & rcvAbort;
    end else begin : g_direct
      assign commitG = 1'b1;
      assign abortG  = 1'b0;
    end
    tpf_ptr i_ptr (
      .clk(clk), .rstN(rstN), .clr(cfgOk),
      .push(partEn & pushReq[g]), .pop(partEn & popReq[g]),
      .commit(commitG), .abort(abortG), .size(sizeR[g]),
      .wrOff(wrOffG), .rdOff(rdOffG),
      .full(full[g]), .empty(empty[g]), .ovf(ovf[g]), .udf(udf[g]),
      .pushOk(pushOkG), .popOk(popOkG)
    );
    assign stb.wrEn[g]   = pushOkG;
    assign stb.wrAddr[g] = baseR[g] + wrOffG;
    assign stb.rdEn[g]   = popOkG;
    assign stb.rdAddr[g] = baseR[g] + rdOffG;
  end

  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    partEn |=> $stable(baseR) && $stable(sizeR));
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !partEn && !cfgWe |=> $stable(empty) && $stable(full) && $stable(udf) && $stable(ovf));
endmodule

// File: rtl/tpf_dpath.sv
module tpf_dpath
  import tpf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  memStb_t               stb,
  input  logic [NP-1:0][DW-1:0] wdata,
  output logic [NP-1:0][DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (stb.wrEn[i]) mem[stb.wrAddr[i]] <= wdata[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else
      for (int i = 0; i < NP; i++)
        if (stb.rdEn[i]) rdata[i] <= mem[stb.rdAddr[i]];
  end

  // R2: data output only moves on an accepted read
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn == '0 |=> $stable(rdata));
endmodule

// File: rtl/tri_part_fifo.sv
module tri_part_fifo
  import tpf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          partEn,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [AW-1:0] cfgBase,
  input  logic [SW-1:0] cfgSize,
  input  logic          asyWe,
  input  logic [DW-1:0] asyWdata,
  input  logic          isoWe,
  input  logic [DW-1:0] isoWdata,
  input  logic          txAsyRe,
  output logic [DW-1:0] txAsyData,
  input  logic          txIsoRe,
  output logic [DW-1:0] txIsoData,
  input  logic          rcvWe,
  input  logic [DW-1:0] rcvWdata,
  input  logic          rcvLast,
  input  logic          rcvAbort,
  input  logic          hostRe,
  output logic [DW-1:0] hostRdata,
  output logic [NP-1:0] full,
  output logic [NP-1:0] empty,
  output logic [NP-1:0] ovfl,
  output logic [NP-1:0] udfl
);
  memStb_t stb;
  logic [NP-1:0][DW-1:0] wd, rd;

  assign wd[P_ASY] = asyWdata;
  assign wd[P_ISO] = isoWdata;
  assign wd[P_RCV] = rcvWdata;
  assign txAsyData = rd[P_ASY];
  assign txIsoData = rd[P_ISO];
  assign hostRdata = rd[P_RCV];

  tpf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .partEn(partEn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .pushReq({rcvWe, isoWe, asyWe}), .popReq({hostRe, txIsoRe, txAsyRe}),
    .rcvLast(rcvLast), .rcvAbort(rcvAbort),
    .stb(stb), .full(full), .empty(empty), .ovf(ovfl), .udf(udfl)
  );

  tpf_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(wd), .rdata(rd)
  );
endmodule

// File: tb/test_tri_part_fifo.sv
`timescale 1ns/1ps
module test_tri_part_fifo;
  logic clk = 1'b0, rstN = 1'b0;
  logic partEn = 0, cfgWe = 0;
  logic [1:0] cfgSel = 0;
  logic [9:0] cfgBase = 0;
  logic [10:0] cfgSize = 0;
  logic asyWe = 0, isoWe = 0, txAsyRe = 0, txIsoRe = 0;
  logic rcvWe = 0, rcvLast = 0, rcvAbort = 0, hostRe = 0;
  logic [31:0] asyWdata = 0, isoWdata = 0, rcvWdata = 0;
  logic [31:0] txAsyData, txIsoData, hostRdata;
  logic [2:0] full, empty, ovfl, udfl;
  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  tri_part_fifo i_tri_part_fifo (.*);

  typedef struct packed {
    logic aWe; logic [7:0] aD; logic tRe;
    logic rWe; logic rLast; logic rAbt; logic [7:0] rD; logic hRe;
    logic [2:0] eFull, eEmpty, eOvf, eUdf; logic [7:0] eTx, eHost;
  } vec_t;

  // queues sized 4 words each before this table runs
  localparam vec_t VT [24] = '{
    '{1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b000,3'b000,8'h00,8'h00}, // R2
    '{1'b1,8'h12,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b000,3'b000,8'h00,8'h00}, // R2
    '{1'b1,8'h13,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b000,3'b000,8'h00,8'h00}, // R2
    '{1'b1,8'h14,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,3'b001,3'b110,3'b000,3'b000,8'h00,8'h00}, // R3 R12
    '{1'b1,8'h15,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,3'b001,3'b110,3'b001,3'b000,8'h00,8'h00}, // R3
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b001,3'b000,8'h11,8'h00}, // R2
    '{1'b1,8'h16,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b001,3'b000,8'h12,8'h00}, // R11
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b001,3'b000,8'h13,8'h00}, // R2
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b110,3'b001,3'b000,8'h14,8'h00}, // R2
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b111,3'b001,3'b000,8'h16,8'h00}, // R5 wrap
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,3'b000,3'b111,3'b001,3'b001,8'h16,8'h00}, // R4
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h21,1'b0,3'b000,3'b111,3'b001,3'b001,8'h16,8'h00}, // R6
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,3'b000,3'b111,3'b001,3'b101,8'h16,8'h00}, // R6 R4
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h22,1'b0,3'b000,3'b011,3'b001,3'b101,8'h16,8'h00}, // R6
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h23,1'b0,3'b000,3'b011,3'b001,3'b101,8'h16,8'h00}, // R8
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h24,1'b0,3'b100,3'b011,3'b001,3'b101,8'h16,8'h00}, // R8
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h25,1'b0,3'b100,3'b011,3'b101,3'b101,8'h16,8'h00}, // R3
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h00,1'b0,3'b000,3'b011,3'b101,3'b101,8'h16,8'h00}, // R7
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,3'b000,3'b011,3'b101,3'b101,8'h16,8'h21}, // R6
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h26,1'b1,3'b000,3'b011,3'b101,3'b101,8'h16,8'h22}, // R11
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,3'b000,3'b111,3'b101,3'b101,8'h16,8'h26}, // R7
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,8'h27,1'b0,3'b000,3'b111,3'b101,3'b101,8'h16,8'h26}, // R7
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h28,1'b0,3'b000,3'b011,3'b101,3'b101,8'h16,8'h26}, // R6
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,3'b000,3'b111,3'b101,3'b101,8'h16,8'h28}  // R7
  };
  localparam int VR [24] = '{2,2,2,3,3,2,11,2,2,5,4,6,6,6,8,8,3,7,6,11,7,7,6,7};

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge already done by caller; let one edge pass, drop strobes
  task automatic tick();
    @(posedge clk); #1;
    cfgWe = 0; asyWe = 0; isoWe = 0; txAsyRe = 0; txIsoRe = 0;
    rcvWe = 0; rcvLast = 0; rcvAbort = 0; hostRe = 0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [9:0] b, input logic [10:0] z);
    @(negedge clk); cfgWe = 1; cfgSel = s; cfgBase = b; cfgSize = z; tick();
  endtask

  task automatic wrA(input logic [31:0] d);
    @(negedge clk); asyWe = 1; asyWdata = d; tick();
  endtask
  task automatic wrI(input logic [31:0] d);
    @(negedge clk); isoWe = 1; isoWdata = d; tick();
  endtask
  task automatic rdA();
    @(negedge clk); txAsyRe = 1; tick();
  endtask
  task automatic rdI();
    @(negedge clk); txIsoRe = 1; tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check("R1 flags after reset", {empty, full, ovfl, udfl}, {3'b111, 3'b000, 3'b000, 3'b000});
    check("R1 data after reset", {txAsyData, hostRdata}, 64'h0);

    // R1 default layout: isochronous queue holds 256 words
    partEn = 1;
    for (int i = 0; i < 255; i++) wrI(32'(i + 1000));
    check("R1 iso not full at 255", full, 3'b000);
    wrI(32'h5000);
    check("R1 iso full at 256 R12", full, 3'b010);
    rdI();
    check("R2 iso first word", txIsoData, 32'd1000);

    // R9 shrink all queues to 4 words
    @(negedge clk); partEn = 0;
    cfg(2'd0, 10'd0, 11'd4);
    cfg(2'd1, 10'd4, 11'd4);
    cfg(2'd2, 10'd8, 11'd4);
    check("R9 layout write empties queues", {empty, full}, {3'b111, 3'b000});
    @(negedge clk); partEn = 1;

    for (int v = 0; v < 24; v++) begin
      @(negedge clk);
      asyWe = VT[v].aWe; asyWdata = {24'h0, VT[v].aD}; txAsyRe = VT[v].tRe;
      rcvWe = VT[v].rWe; rcvLast = VT[v].rLast; rcvAbort = VT[v].rAbt;
      rcvWdata = {24'h0, VT[v].rD}; hostRe = VT[v].hRe;
      tick();
      check($sformatf("R%0d vector %0d", VR[v], v),
            {full, empty, ovfl, udfl, txAsyData, hostRdata},
            {VT[v].eFull, VT[v].eEmpty, VT[v].eOvf, VT[v].eUdf,
             24'h0, VT[v].eTx, 24'h0, VT[v].eHost});
    end

    // R9 layout write ignored while enabled: async stays 4 words, not 1
    cfg(2'd0, 10'd0, 11'd1);
    wrA(32'h55);
    check("R9 locked layout", {full[0], empty[0]}, 2'b00);
    rdA();
    check("R9 locked readback", txAsyData, 32'h55);

    // R10 strobes ignored while disabled
    @(negedge clk); partEn = 0;
    wrA(32'h77);
    rdA();
    @(negedge clk); rcvWe = 1; rcvLast = 1; rcvWdata = 32'h99; tick();
    @(negedge clk); partEn = 1;
    #1;
    check("R10 no effect while off", {empty, ovfl, udfl, txAsyData}, {3'b111, 3'b101, 3'b101, 32'h55});

    // R5 independent queues
    wrI(32'h31); wrI(32'h32); wrA(32'h41);
    rdI();
    check("R5 iso word one", txIsoData, 32'h31);
    rdA();
    check("R5 async word", txAsyData, 32'h41);
    rdI();
    check("R5 iso word two", txIsoData, 32'h32);
    check("R5 sticky untouched", {ovfl, udfl}, {3'b101, 3'b101});

    // R9 accepted layout write clears sticky bits
    wrA(32'h61);
    @(negedge clk); partEn = 0;
    cfg(2'd1, 10'd4, 11'd4);
    check("R9 clear on layout", {empty, ovfl, udfl}, {3'b111, 3'b000, 3'b000});

    summary();
    $finish;
  end
endmodule